// File: doc/BRIEF.md
# Vector Compare Predicate Generator

This sequential unit evaluates one compare operation across a vector of elements and turns the per-element outcomes into a predicate bitmask. The mask is kept in an ordinary integer register, one bit per element. Each of the two source operands is a vector or a scalar, and each is classified separately from its own configured length. A vector operand walks consecutive registers starting at its base. A scalar operand supplies the same register for every element. When neither operand is a vector, no mask is built. The unit evaluates the single compare once and reports it as an ordinary conditional branch outcome.

A run is launched with a one-cycle start strobe that carries the element count, the two base registers, the two operand lengths, the compare code and the destination register. The unit reads operands through two register-file read ports with one cycle of latency. It writes the destination through one write port and raises a done strobe when the run is over. States: IDLE (waiting), CLEAR (zero the destination and issue the read for element 0), STEP (fold one element into the mask, write the mask, issue the next read), FINISH (done pulse), BR_FILL (read the two scalars) and BR_EVAL (branch result with done). Transitions:
- IDLE goes to BR_FILL when start arrives with both operands scalar, and to CLEAR on any other start.
- CLEAR goes to FINISH when the element count is zero, and to STEP otherwise.
- STEP repeats until the last element, then goes to FINISH.
- FINISH returns to IDLE.
- BR_FILL goes to BR_EVAL, and BR_EVAL returns to IDLE.

Top module: `vcp_pred_gen`

## Requirements
- R1: An operand is a vector when its length input is greater than 1. A length of 0 or 1 makes it a scalar.
- R2: For element i, a vector operand reads register (base + i) modulo the register count. A scalar operand reads its base register for every element.
- R3: Compare codes are 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal. Codes 2 and 3 always yield false.
- R4: In the final destination value, bit i is 1 exactly when the element-i compare is true, for i below the element count. Every higher bit is 0. Within a run, each successive write only adds set bits.
- R5: The first write of a run puts zero into the destination in the cycle after start. One further write per element follows in each of the next element-count cycles.
- R6: done_o is high for exactly one cycle, and that cycle is the (count+2)-th after the start edge. A count of 0 leaves a zero mask and gives done in the second cycle.
- R7: When both operands are scalar, nothing is written. branch_o and done_o are high together in the second cycle after start, and branch_taken_o gives the single compare result.
- R8: A start strobe that arrives while a run is in progress is ignored and has no effect on that run's result or timing.
- R9: An element count above the data width is treated as the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| vl_i | input | VLW | Element count |
| src_a_i | input | RW | Base register of operand A |
| src_b_i | input | RW | Base register of operand B |
| vlen_a_i | input | VLW | Configured length of operand A |
| vlen_b_i | input | VLW | Configured length of operand B |
| cmp_op_i | input | 3 | Compare code |
| dst_i | input | RW | Destination register for the mask |
| rf_raddr_a_o | output | RW | Read address for operand A |
| rf_raddr_b_o | output | RW | Read address for operand B |
| rf_rdata_a_i | input | XLEN | Read data A, one cycle after its address |
| rf_rdata_b_i | input | XLEN | Read data B, one cycle after its address |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | RW | Register write address |
| rf_wdata_o | output | XLEN | Register write data |
| done_o | output | 1 | One-cycle completion strobe |
| branch_o | output | 1 | Both-scalar branch result valid |
| branch_taken_o | output | 1 | Branch compare outcome |

## Verification
Results are due at fixed cycles after the start edge:
- the clearing write lands in cycle 1;
- element writes land in cycles 2 through count+1;
- done appears in cycle count+2;
- the branch result appears in cycle 2.

The bench counts cycles from the start edge and samples on the falling edge. For each run it records the cycle in which done appeared and compares that number with count+2, or with 2 for a branch. It checks that done has dropped one cycle later and that the number of writes in the run equals count+1. It reads the final mask from its own register-file model, which takes each write at the edge, only after done.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_STEP,
        ST_FINISH,
        ST_BR_FILL,
        ST_BR_EVAL
    } vcp_state_e;

    localparam logic [2:0] CMP_EQ  = 3'd0;
    localparam logic [2:0] CMP_NE  = 3'd1;
    localparam logic [2:0] CMP_LT  = 3'd4;
    localparam logic [2:0] CMP_GE  = 3'd5;
    localparam logic [2:0] CMP_LTU = 3'd6;
    localparam logic [2:0] CMP_GEU = 3'd7;

endpackage

// File: rtl/vcp_compare.sv
module vcp_compare #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            hit_o
);
    import vcp_pkg::*;

    logic eq, slt, ult;

    always_comb begin
        eq  = (a_i == b_i);
        slt = ($signed(a_i) < $signed(b_i));
        ult = (a_i < b_i);
        case (op_i)
            CMP_EQ:  hit_o = eq;
            CMP_NE:  hit_o = !eq;
            CMP_LT:  hit_o = slt;
            CMP_GE:  hit_o = !slt;
            CMP_LTU: hit_o = ult;
            CMP_GEU: hit_o = !ult;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcp_operand_addr.sv
module vcp_operand_addr #(
    parameter int RW  = 5,
    parameter int VLW = 6
) (
    input  logic [RW-1:0]  base_i,
    input  logic           vec_i,
    input  logic [VLW-1:0] idx_i,
    output logic [RW-1:0]  addr_o
);
    logic [RW-1:0] offs;

    always_comb begin
        offs   = RW'(idx_i);
        addr_o = vec_i ? (base_i + offs) : base_i;
    end
endmodule

// File: rtl/vcp_pred_gen.sv
module vcp_pred_gen #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG),
    localparam int VLW = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VLW-1:0]  vl_i,
    input  logic [RW-1:0]   src_a_i,
    input  logic [RW-1:0]   src_b_i,
    input  logic [VLW-1:0]  vlen_a_i,
    input  logic [VLW-1:0]  vlen_b_i,
    input  logic [2:0]      cmp_op_i,
    input  logic [RW-1:0]   dst_i,
    output logic [RW-1:0]   rf_raddr_a_o,
    output logic [RW-1:0]   rf_raddr_b_o,
    input  logic [XLEN-1:0] rf_rdata_a_i,
    input  logic [XLEN-1:0] rf_rdata_b_i,
    output logic            rf_we_o,
    output logic [RW-1:0]   rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            done_o,
    output logic            branch_o,
    output logic            branch_taken_o
);
    import vcp_pkg::*;

    localparam logic [VLW-1:0] VL_CAP = VLW'(XLEN);

    vcp_state_e     state, state_nx;
    logic [RW-1:0]  base_q [2];
    logic [1:0]     vec_q;
    logic [2:0]     op_q;
    logic [RW-1:0]  dst_q;
    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] idx_q;
    logic [XLEN-1:0] acc_q;

    logic [VLW-1:0] rd_idx;
    logic [RW-1:0]  raddr [2];
    logic           hit;
    logic [XLEN-1:0] acc_nx;
    logic           last_elem;
    logic           a_is_vec, b_is_vec;

    // R1: classification of each operand from its own length
    assign a_is_vec = (vlen_a_i > VLW'(1));
    assign b_is_vec = (vlen_b_i > VLW'(1));

    // R2: element addressing, one generator per operand
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_opnd
            vcp_operand_addr #(.RW(RW), .VLW(VLW)) u_addr (
                .base_i (base_q[g]),
                .vec_i  (vec_q[g]),
                .idx_i  (rd_idx),
                .addr_o (raddr[g])
            );
        end
    endgenerate

    assign rf_raddr_a_o = raddr[0];
    assign rf_raddr_b_o = raddr[1];

    // R3: compare on returned data
    vcp_compare #(.XLEN(XLEN)) u_cmp (
        .op_i  (op_q),
        .a_i   (rf_rdata_a_i),
        .b_i   (rf_rdata_b_i),
        .hit_o (hit)
    );

    always_comb begin
        rd_idx    = (state == ST_STEP) ? (idx_q + VLW'(1)) : '0;
        last_elem = (idx_q == (vl_q - VLW'(1)));
        acc_nx    = acc_q | (XLEN'(hit) << idx_q);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!a_is_vec && !b_is_vec) state_nx = ST_BR_FILL;
                    else                        state_nx = ST_CLEAR;
                end
            end
            ST_CLEAR:   state_nx = (vl_q == '0) ? ST_FINISH : ST_STEP;
            ST_STEP:    state_nx = last_elem ? ST_FINISH : ST_STEP;
            ST_FINISH:  state_nx = ST_IDLE;
            ST_BR_FILL: state_nx = ST_BR_EVAL;
            ST_BR_EVAL: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q[0] <= '0;
            base_q[1] <= '0;
            vec_q     <= '0;
            op_q      <= '0;
            dst_q     <= '0;
            vl_q      <= '0;
            idx_q     <= '0;
            acc_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        // R8: operands latched only in IDLE
                        base_q[0] <= src_a_i;
                        base_q[1] <= src_b_i;
                        vec_q     <= {b_is_vec, a_is_vec};
                        op_q      <= cmp_op_i;
                        dst_q     <= dst_i;
                        // R9: clamp element count
                        vl_q      <= (vl_i > VL_CAP) ? VL_CAP : vl_i;
                    end
                end
                ST_CLEAR: begin
                    idx_q <= '0;
                    acc_q <= '0;
                end
                ST_STEP: begin
                    idx_q <= idx_q + VLW'(1);
                    acc_q <= acc_nx;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rf_we_o        = 1'b0;
        rf_waddr_o     = dst_q;
        rf_wdata_o     = '0;
        done_o         = 1'b0;
        branch_o       = 1'b0;
        branch_taken_o = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                rf_we_o    = 1'b1;
                rf_wdata_o = '0;
            end
            ST_STEP: begin
                rf_we_o    = 1'b1;
                rf_wdata_o = acc_nx;
            end
            ST_FINISH: done_o = 1'b1;
            ST_BR_EVAL: begin
                done_o         = 1'b1;
                branch_o       = 1'b1;
                branch_taken_o = hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vcp_checker.sv
module vcp_checker #(
    parameter int XLEN = 32,
    parameter int RW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rf_we_o,
    input logic [XLEN-1:0] rf_wdata_o,
    input logic            done_o,
    input logic            branch_o,
    input logic            branch_taken_o
);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_first_write_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !$past(rf_we_o)) |-> (rf_wdata_o == '0));

    assert_mask_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && $past(rf_we_o)) |-> (($past(rf_wdata_o) & ~rf_wdata_o) == '0));

    assert_branch_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> (done_o && !rf_we_o));

    assert_taken_needs_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |-> branch_o);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !rf_we_o);
endmodule

bind vcp_pred_gen vcp_checker #(.XLEN(XLEN), .RW(RW)) u_vcp_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rf_we_o        (rf_we_o),
    .rf_wdata_o     (rf_wdata_o),
    .done_o         (done_o),
    .branch_o       (branch_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/sim_vcp_pred_gen.sv
`timescale 1ns/1ps
module sim_vcp_pred_gen;
    localparam int XLEN = 32;
    localparam int NREG = 64;
    localparam int RW   = 6;
    localparam int VLW  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [VLW-1:0] vl_i = '0, vlen_a_i = '0, vlen_b_i = '0;
    logic [RW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
    logic [2:0] cmp_op_i = '0;
    logic [RW-1:0] rf_raddr_a_o, rf_raddr_b_o, rf_waddr_o;
    logic [XLEN-1:0] rf_rdata_a_i, rf_rdata_b_i, rf_wdata_o;
    logic rf_we_o, done_o, branch_o, branch_taken_o;

    logic [XLEN-1:0] rf [NREG];
    int nwr = 0;
    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vcp_pred_gen #(.XLEN(XLEN), .NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .vlen_a_i(vlen_a_i),
        .vlen_b_i(vlen_b_i), .cmp_op_i(cmp_op_i), .dst_i(dst_i),
        .rf_raddr_a_o(rf_raddr_a_o), .rf_raddr_b_o(rf_raddr_b_o),
        .rf_rdata_a_i(rf_rdata_a_i), .rf_rdata_b_i(rf_rdata_b_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .done_o(done_o), .branch_o(branch_o), .branch_taken_o(branch_taken_o)
    );

    // register-file model: one-cycle read latency
    always @(posedge clk) begin
        rf_rdata_a_i <= rf[rf_raddr_a_o];
        rf_rdata_b_i <= rf[rf_raddr_b_o];
        if (rf_we_o) begin
            rf[rf_waddr_o] <= rf_wdata_o;
            nwr = nwr + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ref_cmp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a < b;
            3'd7: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input int vl, input int sa, input int sb, input int la, input int lb,
                       input int op, input int dst, input bit interfere);
        int eff;
        bit va, vb;
        logic [31:0] exp_mask;
        bit exp_br;
        int cyc;
        int done_cyc;
        eff = (vl > XLEN) ? XLEN : vl;
        va = la > 1;
        vb = lb > 1;
        exp_mask = '0;
        for (int i = 0; i < eff; i++) begin
            logic [31:0] ea, eb;
            ea = rf[va ? ((sa + i) % NREG) : sa];
            eb = rf[vb ? ((sb + i) % NREG) : sb];
            if (ref_cmp(3'(op), ea, eb)) exp_mask[i] = 1'b1;
        end
        exp_br = ref_cmp(3'(op), rf[sa], rf[sb]);
        rf[dst] = 32'hDEAD_BEEF;
        @(negedge clk);
        vl_i = VLW'(vl); src_a_i = RW'(sa); src_b_i = RW'(sb);
        vlen_a_i = VLW'(la); vlen_b_i = VLW'(lb); cmp_op_i = 3'(op); dst_i = RW'(dst);
        start_i = 1'b1;
        nwr = 0;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        done_cyc = -1;
        while (cyc < 80) begin
            if (done_o) begin
                done_cyc = cyc;
                break;
            end
            // R8: stray start while busy, with different operands
            if (interfere && cyc == 3) begin
                start_i = 1'b1; vl_i = 6'd1; cmp_op_i = 3'd0; dst_i = RW'(dst - 1);
                src_a_i = 6'd7; src_b_i = 6'd7; vlen_a_i = 6'd1; vlen_b_i = 6'd1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (!va && !vb) begin
            chk(done_cyc == 2, "R7 branch done cycle", done_cyc, 2);
            chk(branch_o == 1'b1, "R7 branch flag", branch_o, 1);
            chk(branch_taken_o == exp_br, "R7 branch outcome", branch_taken_o, exp_br);
            chk(nwr == 0, "R7 no write", nwr, 0);
        end else begin
            chk(done_cyc == eff + 2, "R6 done cycle", done_cyc, eff + 2);
            chk(branch_o == 1'b0, "R7 no branch in loop", branch_o, 0);
            chk(nwr == eff + 1, "R5 write count", nwr, eff + 1);
            chk(rf[dst] == exp_mask, "R4 mask", rf[dst], exp_mask);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R6 single done", done_o, 0);
        chk(nwr == ((!va && !vb) ? 0 : eff + 1), "R8 no extra writes", nwr,
            (!va && !vb) ? 0 : eff + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int vls [7] = '{0, 1, 2, 3, 7, 16, 24};
        for (int i = 0; i < NREG; i++) rf[i] = 32'(((i * 37) % 11) - 5);
        repeat (3) @(negedge clk);
        chk(done_o == 0 && rf_we_o == 0 && branch_o == 0, "R6 reset quiet",
            {done_o, rf_we_o, branch_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R3 R4: sweep codes, counts and operand shapes
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 7; k++) begin
                run(vls[k], 1, 33, 4, 9, op, 62, 0);   // vector-vector
                run(vls[k], 1, 40, 4, 1, op, 62, 0);   // vector-scalar (length 1)
                run(vls[k], 5, 33, 0, 2, op, 62, 0);   // scalar (length 0)-vector
            end
        end
        // R7: both scalar, several pairs incl. equal and signed/unsigned split
        for (int op = 0; op < 8; op++) begin
            run(5, 2, 3, 1, 0, op, 62, 0);
            run(5, 4, 4, 0, 0, op, 62, 0);
            run(9, 0, 9, 1, 1, op, 62, 0);
            run(0, 10, 6, 0, 1, op, 62, 0);
        end
        // R9: count above data width clamps to 32
        run(40, 0, 40, 32, 1, 6, 63, 0);
        run(33, 0, 40, 2, 0, 4, 63, 0);
        // R2: vector wraps around the register count
        run(8, 60, 20, 3, 3, 5, 40, 0);
        // R8: start while busy is ignored
        run(10, 1, 33, 4, 4, 6, 62, 1);
        run(0, 1, 33, 4, 4, 1, 62, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule